// File: doc/BRIEF.md
# Dual-Pixel Streaming Integral Image Engine

This block turns a raster-scanned greyscale frame, delivered as two adjacent 8-bit pixels per clock, into its integral image at the same rate. Each output value is the sum of every pixel whose row and column are both less than or equal to that output's own position. It emits two values, one for the even column of the pair and one for the odd column, on every clock that carried a pair three clocks earlier.

The block does not keep the previous row's integral values. Its line buffer holds one narrow vertical running sum per column. Each entry is the sum of that column's pixels from the top of the frame down to the current row. A single running register rebuilds the absolute integral value along the row. The register is cleared at every line start, and after each pair it takes the odd output. A line-buffer word therefore needs only enough bits for one column of the frame, not for the whole frame. Each pair address is read one cycle early and written back with the new sum one cycle later.

The upstream source marks the first pair of a frame and the first pair of each line. The block has no flow control: it takes every pair that arrives with `pix_valid` high.

Top module: `ii_pair_engine`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is low until a pair has been accepted.
- R2: `out_valid` is high exactly three clock edges after an edge at which `pix_valid` was high, so idle gaps in the input keep their spacing at the output.
- R3: For the pair at columns 2k and 2k+1 of row y, with the pixel of column 2k on `pix_pair[7:0]` and the pixel of column 2k+1 on `pix_pair[15:8]`, `out_ii_even` is the sum of all pixels in rows 0..y and columns 0..2k, and `out_ii_odd` is the same sum over columns 0..2k+1.
- R4: On the row that begins with `pix_sof`, the column sums start from zero, so whatever an earlier frame left in the line buffer does not reach the output.
- R5: On a pair that carries `pix_sol` (or `pix_sof`), `out_ii_even` equals that column's vertical sum alone, with no carry-over from the previous row's running value.
- R6: When rows follow one another with no idle cycle between them, each row uses the column sums that the row before it wrote.
- R7: For an all-255 frame, the odd value of the last pair equals IMG_W*IMG_H*255 with no truncation, and no output ever exceeds that bound.
- R8: `out_sof` and `out_sol` are high on the output of the pair that carried `pix_sof` or `pix_sol`, and `out_sof` implies `out_sol`.
- R9: While `pix_valid` is low, `pix_pair`, `pix_sof` and `pix_sol` have no effect: idle cycles inserted anywhere in a frame leave every output value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | A pixel pair is present this cycle |
| pix_sof | input | 1 | Pair is the first of a frame (also starts a line) |
| pix_sol | input | 1 | Pair is the first of a line |
| pix_pair | input | 16 | [7:0] even-column pixel, [15:8] odd-column pixel |
| out_valid | output | 1 | Integral pair present |
| out_sof | output | 1 | Output pair is the first of a frame |
| out_sol | output | 1 | Output pair is the first of a line |
| out_ii_even | output | II_W | Integral value at the even column |
| out_ii_odd | output | II_W | Integral value at the odd column |

## Verification
The main function is driven with several frame types: random pixels, all-255 frames, all-zero frames and a ramp. Random frames find mix-ups between the even and odd lanes and between rows. All-255 frames press the widest sums and the bottom-right corner. All-zero frames show whether stale line-buffer contents leak into a new frame. The ramp gives each position a distinct value, so any off-by-one in addressing shows. Each frame type runs with no idle cycles, with random idle cycles between pairs, and with idle cycles only between rows. During idle cycles the data bus and markers are driven with junk. Together these runs separate read-after-write ordering, running-register clearing and gating errors.

// File: rtl/ii_pkg.sv
package ii_pkg;

    localparam int PIX_W = 8;

    typedef struct packed {
        logic sof;
        logic sol;
    } ii_mark_t;

    function automatic int ii_addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/ii_raster_ctrl.sv
module ii_raster_ctrl
    import ii_pkg::*;
#(
    parameter int IMG_W  = 128,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic              pix_sol,
    input  logic [2*PIX_W-1:0] pix_pair,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              s1_vld,
    output ii_mark_t          s1_mark,
    output logic              s1_first,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [PIX_W-1:0]  s1_pix_even,
    output logic [PIX_W-1:0]  s1_pix_odd
);

    localparam int PAIRS = IMG_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] col;
        logic              first;
        logic              vld;
        ii_mark_t          mark;
        logic              s_first;
        logic [ADDR_W-1:0] addr;
        logic [PIX_W-1:0]  pe;
        logic [PIX_W-1:0]  po;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic              line_start;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_first;

    always_comb begin
        line_start = pix_sof | pix_sol;
        cur_addr   = line_start ? '0 : st_q.col;
        cur_first  = pix_sof ? 1'b1 : (pix_sol ? 1'b0 : st_q.first);

        st_d     = st_q;
        st_d.vld = pix_valid;
        if (pix_valid) begin
            st_d.col      = (int'(cur_addr) == PAIRS - 1) ? '0 : cur_addr + 1'b1;
            st_d.first    = cur_first;
            st_d.mark.sof = pix_sof;
            st_d.mark.sol = line_start;
            st_d.s_first  = cur_first;
            st_d.addr     = cur_addr;
            st_d.pe       = pix_pair[PIX_W-1:0];
            st_d.po       = pix_pair[2*PIX_W-1:PIX_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en       = pix_valid;
    assign rd_addr     = cur_addr;
    assign s1_vld      = st_q.vld;
    assign s1_mark     = st_q.mark;
    assign s1_first    = st_q.s_first;
    assign s1_addr     = st_q.addr;
    assign s1_pix_even = st_q.pe;
    assign s1_pix_odd  = st_q.po;

endmodule

// File: rtl/ii_line_buf.sv
module ii_line_buf #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 15,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [1:0][WORD_W-1:0] wr_data,
    output logic [1:0][WORD_W-1:0] rd_data
);

    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic [WORD_W-1:0] mem [DEPTH];
        logic [WORD_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data[lane];
            end
            if (rd_en) begin
                if (wr_en && (wr_addr == rd_addr)) begin
                    rd_q <= wr_data[lane];
                end else begin
                    rd_q <= mem[rd_addr];
                end
            end
        end

        assign rd_data[lane] = rd_q;
    end

endmodule

// File: rtl/ii_col_update.sv
module ii_col_update
    import ii_pkg::*;
#(
    parameter int CS_W   = 11,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_vld,
    input  ii_mark_t               s1_mark,
    input  logic                   s1_first,
    input  logic [ADDR_W-1:0]      s1_addr,
    input  logic [PIX_W-1:0]       s1_pix_even,
    input  logic [PIX_W-1:0]       s1_pix_odd,
    input  logic [1:0][CS_W-1:0]   prev_sum,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [1:0][CS_W-1:0]   wr_data,
    output logic                   s2_vld,
    output ii_mark_t               s2_mark,
    output logic [CS_W-1:0]        s2_col_even,
    output logic [CS_W-1:0]        s2_col_odd
);

    typedef struct packed {
        logic            vld;
        ii_mark_t        mark;
        logic [CS_W-1:0] ce;
        logic [CS_W-1:0] co;
    } col_t;

    col_t st_d, st_q;
    logic [CS_W-1:0] base_e, base_o, sum_e, sum_o;

    always_comb begin
        base_e = s1_first ? '0 : prev_sum[0];
        base_o = s1_first ? '0 : prev_sum[1];
        sum_e  = base_e + CS_W'(s1_pix_even);
        sum_o  = base_o + CS_W'(s1_pix_odd);

        st_d     = st_q;
        st_d.vld = s1_vld;
        if (s1_vld) begin
            st_d.mark = s1_mark;
            st_d.ce   = sum_e;
            st_d.co   = sum_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en       = s1_vld;
    assign wr_addr     = s1_addr;
    assign wr_data     = {sum_o, sum_e};
    assign s2_vld      = st_q.vld;
    assign s2_mark     = st_q.mark;
    assign s2_col_even = st_q.ce;
    assign s2_col_odd  = st_q.co;

endmodule

// File: rtl/ii_row_accum.sv
module ii_row_accum
    import ii_pkg::*;
#(
    parameter int CS_W = 11,
    parameter int II_W = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s2_vld,
    input  ii_mark_t        s2_mark,
    input  logic [CS_W-1:0] s2_col_even,
    input  logic [CS_W-1:0] s2_col_odd,
    output logic            out_valid,
    output logic            out_sof,
    output logic            out_sol,
    output logic [II_W-1:0] out_ii_even,
    output logic [II_W-1:0] out_ii_odd
);

    typedef struct packed {
        logic [II_W-1:0] acc;
        logic            vld;
        ii_mark_t        mark;
        logic [II_W-1:0] ie;
        logic [II_W-1:0] io;
    } acc_t;

    acc_t st_d, st_q;
    logic [II_W-1:0] run_base, val_e, val_o;

    always_comb begin
        run_base = s2_mark.sol ? '0 : st_q.acc;
        val_e    = run_base + II_W'(s2_col_even);
        val_o    = val_e + II_W'(s2_col_odd);

        st_d     = st_q;
        st_d.vld = s2_vld;
        if (s2_vld) begin
            st_d.acc  = val_o;
            st_d.mark = s2_mark;
            st_d.ie   = val_e;
            st_d.io   = val_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_sof     = st_q.vld & st_q.mark.sof;
    assign out_sol     = st_q.vld & st_q.mark.sol;
    assign out_ii_even = st_q.ie;
    assign out_ii_odd  = st_q.io;

endmodule

// File: rtl/ii_pair_engine.sv
module ii_pair_engine
    import ii_pkg::*;
#(
    parameter int IMG_W = 128,
    parameter int IMG_H = 96,
    localparam int II_W = $clog2(IMG_W * IMG_H * 255 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic              pix_sol,
    input  logic [15:0]       pix_pair,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [II_W-1:0]   out_ii_even,
    output logic [II_W-1:0]   out_ii_odd
);

    localparam int PAIRS  = IMG_W / 2;
    localparam int ADDR_W = ii_addr_bits(PAIRS);
    localparam int CS_W   = $clog2(IMG_H * 255 + 1);

    logic                 lb_rd_en;
    logic [ADDR_W-1:0]    lb_rd_addr;
    logic                 lb_wr_en;
    logic [ADDR_W-1:0]    lb_wr_addr;
    logic [1:0][CS_W-1:0] lb_wr_data;
    logic [1:0][CS_W-1:0] lb_rd_data;

    logic              s1_vld, s1_first;
    ii_mark_t          s1_mark;
    logic [ADDR_W-1:0] s1_addr;
    logic [PIX_W-1:0]  s1_pix_even, s1_pix_odd;

    logic              s2_vld;
    ii_mark_t          s2_mark;
    logic [CS_W-1:0]   s2_col_even, s2_col_odd;

    ii_raster_ctrl #(.IMG_W(IMG_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_pair(pix_pair),
        .rd_en(lb_rd_en), .rd_addr(lb_rd_addr),
        .s1_vld(s1_vld), .s1_mark(s1_mark), .s1_first(s1_first), .s1_addr(s1_addr),
        .s1_pix_even(s1_pix_even), .s1_pix_odd(s1_pix_odd)
    );

    ii_line_buf #(.DEPTH(PAIRS), .WORD_W(CS_W), .ADDR_W(ADDR_W)) u_lbuf (
        .clk(clk),
        .rd_en(lb_rd_en), .rd_addr(lb_rd_addr),
        .wr_en(lb_wr_en), .wr_addr(lb_wr_addr), .wr_data(lb_wr_data),
        .rd_data(lb_rd_data)
    );

    ii_col_update #(.CS_W(CS_W), .ADDR_W(ADDR_W)) u_col (
        .clk(clk), .rst_n(rst_n),
        .s1_vld(s1_vld), .s1_mark(s1_mark), .s1_first(s1_first), .s1_addr(s1_addr),
        .s1_pix_even(s1_pix_even), .s1_pix_odd(s1_pix_odd),
        .prev_sum(lb_rd_data),
        .wr_en(lb_wr_en), .wr_addr(lb_wr_addr), .wr_data(lb_wr_data),
        .s2_vld(s2_vld), .s2_mark(s2_mark), .s2_col_even(s2_col_even), .s2_col_odd(s2_col_odd)
    );

    ii_row_accum #(.CS_W(CS_W), .II_W(II_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .s2_vld(s2_vld), .s2_mark(s2_mark), .s2_col_even(s2_col_even), .s2_col_odd(s2_col_odd),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_ii_even(out_ii_even), .out_ii_odd(out_ii_odd)
    );

endmodule

// File: rtl/ii_pair_engine_chk.sv
module ii_pair_engine_chk #(
    parameter int IMG_W  = 128,
    parameter int IMG_H  = 96,
    parameter int II_W   = 22,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              out_valid,
    input logic              out_sof,
    input logic              out_sol,
    input logic [II_W-1:0]   out_ii_even,
    input logic [II_W-1:0]   out_ii_odd,
    input logic              lb_wr_en,
    input logic [ADDR_W-1:0] lb_wr_addr
);

    localparam longint MAX_II = longint'(IMG_W) * IMG_H * 255;

    logic [2:0]      vhist;
    logic            in_line;
    logic [II_W-1:0] last_odd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vhist    <= '0;
            in_line  <= 1'b0;
            last_odd <= '0;
        end else begin
            vhist <= {vhist[1:0], pix_valid};
            if (out_valid) begin
                in_line  <= 1'b1;
                last_odd <= out_ii_odd;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[2]); // R2
    AST_ODD_GE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ii_odd >= out_ii_even); // R3
    AST_ROW_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sol && in_line) |-> out_ii_even >= last_odd); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> longint'(out_ii_odd) <= MAX_II); // R7
    AST_SOF_IS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol); // R8
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_ii_even <= II_W'(255)); // R4
    AST_LBUF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr_en |-> int'(lb_wr_addr) < IMG_W / 2); // R6

endmodule

bind ii_pair_engine ii_pair_engine_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .II_W(II_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_ii_even(out_ii_even), .out_ii_odd(out_ii_odd),
    .lb_wr_en(lb_wr_en), .lb_wr_addr(lb_wr_addr)
);

// File: tb/ii_pair_engine_bench.sv
module ii_pair_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int H    = 6;
    localparam int PW   = W / 2;
    localparam int IIW  = $clog2(W * H * 255 + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pix_valid = 1'b0;
    logic           pix_sof = 1'b0;
    logic           pix_sol = 1'b0;
    logic [15:0]    pix_pair = '0;
    logic           out_valid, out_sof, out_sol;
    logic [IIW-1:0] out_ii_even, out_ii_odd;

    int img [H][W];
    int n_chk = 0;
    int n_bad = 0;
    int ox = 0, oy = 0;
    int cur_kind = 0, cur_gap = 0, frame_no = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [2:0] vh = '0;

    ii_pair_engine #(.IMG_W(W), .IMG_H(H)) u_ii_pair_engine (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_pair(pix_pair),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_ii_even(out_ii_even), .out_ii_odd(out_ii_odd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ref_ii(input int x, input int y);
        int s = 0;
        for (int r = 0; r <= y; r++)
            for (int c = 0; c <= x; c++)
                s += img[r][c];
        return s;
    endfunction

    function automatic int col_sum(input int x, input int y);
        int s = 0;
        for (int r = 0; r <= y; r++) s += img[r][x];
        return s;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (frame %0d row %0d pair %0d)",
                     tag, act, exp, frame_no, oy, ox);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        vh  <= {vh[1:0], pix_valid};
    end

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            check("R2 valid timing", longint'(out_valid), longint'(vh[2]));
            if (out_valid) begin
                string tag;
                if (ox == 0)                      tag = "R5";
                else if (oy == 0 && frame_no > 0) tag = "R4";
                else if (cur_gap == 0 && oy > 0)  tag = "R6";
                else if (cur_gap == 1)            tag = "R9";
                else                              tag = "R3";
                check({tag, " even"}, longint'(out_ii_even), longint'(ref_ii(2 * ox, oy)));
                check({tag, " odd"},  longint'(out_ii_odd),  longint'(ref_ii(2 * ox + 1, oy)));
                if (ox == 0)
                    check("R5 line start equals column sum", longint'(out_ii_even),
                          longint'(col_sum(0, oy)));
                check("R8 sof", longint'(out_sof), longint'(ox == 0 && oy == 0));
                check("R8 sol", longint'(out_sol), longint'(ox == 0));
                if (cur_kind == 1 && ox == PW - 1 && oy == H - 1)
                    check("R7 corner", longint'(out_ii_odd), longint'(W * H * 255));
                ox++;
                if (ox == PW) begin
                    ox = 0;
                    oy++;
                end
            end
        end
    end

    task automatic idle_cycle();
        @(negedge clk);
        pix_valid = 1'b0;
        pix_pair  = 16'($urandom);
        pix_sof   = 1'($urandom);
        pix_sol   = 1'($urandom);
    endtask

    task automatic run_frame(input int kind, input int gap);
        cur_kind = kind;
        cur_gap  = gap;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                case (kind)
                    0: img[y][x] = int'($urandom % 256);
                    1: img[y][x] = 255;
                    2: img[y][x] = 0;
                    default: img[y][x] = (x * 7 + y * 31) % 256;
                endcase
        ox = 0;
        oy = 0;
        for (int y = 0; y < H; y++) begin
            if (gap == 2 && y > 0)
                for (int i = 0; i < 3; i++) idle_cycle();
            for (int k = 0; k < PW; k++) begin
                if (gap == 1) begin
                    int n = int'($urandom % 3);
                    for (int i = 0; i < n; i++) idle_cycle();
                end
                @(negedge clk);
                pix_valid = 1'b1;
                pix_pair  = {8'(img[y][2 * k + 1]), 8'(img[y][2 * k])};
                pix_sof   = (y == 0 && k == 0);
                pix_sol   = (k == 0);
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_sol   = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 frame complete", longint'(oy), longint'(H));
        frame_no++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", longint'(out_valid), 0);
        mon_on = 1'b1;
        for (int rep = 0; rep < 2; rep++)
            for (int kind = 0; kind < 4; kind++)
                for (int gap = 0; gap < 3; gap++)
                    run_frame(kind, gap);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule